// File: doc/BRIEF.md
# Packet-command PIO read sequencer

This block is the device side of a packet command on a disk-style task-file interface, for programmed-I/O transfers. The host issues the packet command code with a byte-count limit and then writes a 12-byte command block as six 16-bit words through the data port. The only command block acted on is a 10-byte-style read, which names a starting block address and a number of 2048-byte blocks.

For a read, the sequencer opens a stream on a block source through a valid/ready handshake and returns the data through the data port. The data is split into bursts. Each burst is no larger than the host's limit rounded down to an even number, and only the last burst may be shorter. An interrupt announces each burst, and the byte count of the current burst can be read back. One more interrupt, with the data request flag clear, marks the end of the command.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset, busy, data request and interrupt are low and ready is high.
- R2: Only command code 0xA0 with the DMA select bit clear is accepted, and only while idle. If the DMA select bit is set, or any other command code is given, nothing changes: busy, data request and interrupt stay low.
- R3: An accepted packet command sets busy for one cycle. Data request then rises with ready high and busy low while six command words are taken. Busy and data request are never high together.
- R4: Byte 2k of the command block is bits 7:0 of word k and byte 2k+1 is bits 15:8. Byte 0 is the opcode, and 0x28 means read. Bytes 2 to 5 hold the block address, most significant byte first, and bytes 7 and 8 hold the block count, most significant byte first. `src_lba` and `src_blocks` carry these two values when `src_open` pulses.
- R5: The even limit is the byte-count limit with bit 0 cleared. A limit below 2 counts as 2. Each burst is the smaller of the even limit and the bytes still to send, and `bc_out` holds that size while the burst runs.
- R6: At the start of every burst the interrupt rises together with data request, with busy low. A pulse on `intr_ack` clears the interrupt.
- R7: Once the last data word has been read, the interrupt rises with data request and busy low and ready high.
- R8: A block count of zero, or an opcode other than 0x28, ends the command right after the sixth word with the final interrupt. The source is not opened and no data phase follows.
- R9: Exactly count × 1024 words are delivered, in the order the source gives them.
- R10: While a source word is awaited, busy is high and data request is low. A source that stalls loses no word.
- R11: The limit is sampled when the packet command is accepted. Changing `bcl` afterwards does not change the burst sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command code |
| dma_sel | input | 1 | Feature bit 0: DMA data phase requested |
| bcl | input | 16 | Byte-count limit (cylinder registers) |
| wr_valid | input | 1 | Data port write strobe |
| wr_data | input | 16 | Data port write word |
| rd_valid | input | 1 | Data port read strobe |
| rd_data | output | 16 | Data port read word |
| intr_ack | input | 1 | Status read: clears the interrupt |
| bsy | output | 1 | Busy |
| drdy | output | 1 | Device ready |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| bc_out | output | 16 | Byte count of the current burst |
| src_open | output | 1 | Pulse that starts a source stream |
| src_lba | output | 32 | Stream start block address |
| src_blocks | output | 16 | Stream length in blocks |
| src_ready | output | 1 | Sequencer takes a source word |
| src_valid | input | 1 | Source word available |
| src_data | input | 16 | Source word |

## Verification
Reads are run with a limit larger than the whole transfer, a large limit that splits three blocks into one full and one short burst, an odd limit that leaves a short tail, and a limit of 1 that produces one-word bursts; together these separate min-selection, even rounding and the floor at 2. A source that stalls most cycles shows whether words are dropped or repeated across busy gaps. A zero count, a foreign opcode, DMA select and a non-packet code each show that the data phase and source stream are skipped, and a mid-transfer change of `bcl` shows that the limit is held from issue.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam logic [7:0] OP_READ10 = 8'h28;
  localparam int BLK_CNT_W = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_PKT_BSY, S_PKT_RX, S_FILL, S_XFER
  } seq_state_e;

  // Even-rounded limit; anything below 2 becomes 2 so a burst is never empty.
  function automatic logic [15:0] even_limit(input logic [15:0] raw);
    logic [15:0] e;
    e = {raw[15:1], 1'b0};
    return (e == 16'd0) ? 16'd2 : e;
  endfunction

  // Burst size: limit, or whatever remains if that is smaller.
  function automatic logic [15:0] burst_size(input logic [15:0] lim,
                                             input logic [31:0] rem);
    return (rem < {16'd0, lim}) ? rem[15:0] : lim;
  endfunction
endpackage

// File: rtl/atapi_cdb_rx.sv
module atapi_cdb_rx #(
  parameter int CDB_WORDS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        full,
  output logic [7:0]  opcode,
  output logic [31:0] lba,
  output logic [15:0] blocks
);
  localparam int IDX_W = $clog2(CDB_WORDS + 1);

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       op_q;
  logic [31:0]      lba_q;
  logic [15:0]      blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      op_q  <= '0;
      lba_q <= '0;
      blk_q <= '0;
    end else if (clr) begin
      idx_q <= '0;
    end else if (wr_en && (idx_q < IDX_W'(CDB_WORDS))) begin
      idx_q <= idx_q + 1'b1;
      // Low byte of word k is byte 2k; multi-byte fields are big-endian.
      case (idx_q)
        IDX_W'(0): op_q          <= wr_data[7:0];
        IDX_W'(1): lba_q[31:16]  <= {wr_data[7:0], wr_data[15:8]};
        IDX_W'(2): lba_q[15:0]   <= {wr_data[7:0], wr_data[15:8]};
        IDX_W'(3): blk_q[15:8]   <= wr_data[15:8];
        IDX_W'(4): blk_q[7:0]    <= wr_data[7:0];
        default: ;
      endcase
    end
  end

  assign full   = (idx_q == IDX_W'(CDB_WORDS));
  assign opcode = op_q;
  assign lba    = lba_q;
  assign blocks = blk_q;

  AST_CDB_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(CDB_WORDS)); // R3
endmodule

// File: rtl/atapi_xfer_ctr.sv
module atapi_xfer_ctr
  import atapi_seq_pkg::*;
#(
  parameter int BLK_BYTES = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [BLK_CNT_W-1:0] blocks,
  input  logic [15:0]          lim,
  input  logic                 start,
  input  logic                 consume,
  output logic                 last_all,
  output logic                 last_burst,
  output logic [15:0]          bc
);
  localparam int BLK_LOG = $clog2(BLK_BYTES);
  localparam int REM_W   = BLK_CNT_W + BLK_LOG;

  logic [REM_W-1:0] rem_q;
  logic [15:0]      left_q;
  logic [15:0]      bc_q;
  logic [15:0]      next_burst;

  assign next_burst = burst_size(lim, 32'(rem_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      left_q <= '0;
      bc_q   <= '0;
    end else begin
      if (load) rem_q <= {blocks, {BLK_LOG{1'b0}}};
      else if (consume) rem_q <= rem_q - REM_W'(2);
      if (start) begin
        left_q <= next_burst;
        bc_q   <= next_burst;
      end else if (consume) begin
        left_q <= left_q - 16'd2;
      end
    end
  end

  assign last_all   = (rem_q == REM_W'(2));
  assign last_burst = (left_q == 16'd2);
  assign bc         = bc_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> (rem_q >= REM_W'(2)) && (left_q >= 16'd2)); // R9
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bc_q <= $past(lim)) && (bc_q != 16'd0) && !bc_q[0]); // R5
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_seq_pkg::*;
#(
  parameter int BLK_BYTES = 2048,
  parameter int CDB_WORDS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_code,
  input  logic                 dma_sel,
  input  logic [15:0]          bcl,
  input  logic                 wr_valid,
  input  logic [15:0]          wr_data,
  input  logic                 rd_valid,
  output logic [15:0]          rd_data,
  input  logic                 intr_ack,
  output logic                 bsy,
  output logic                 drdy,
  output logic                 drq,
  output logic                 intrq,
  output logic [15:0]          bc_out,
  output logic                 src_open,
  output logic [31:0]          src_lba,
  output logic [BLK_CNT_W-1:0] src_blocks,
  output logic                 src_ready,
  input  logic                 src_valid,
  input  logic [15:0]          src_data
);
  seq_state_e  state_q, state_d;
  logic [15:0] lim_q;
  logic [15:0] hold_q;
  logic        need_burst_q;
  logic        intr_q;

  logic        cdb_full;
  logic [7:0]  cdb_op;
  logic [31:0] cdb_lba;
  logic [15:0] cdb_blocks;
  logic        last_all, last_burst;

  // Named events used by the control logic and by the assertions.
  logic accept_ev, cdb_wr_ev, decode_ev, rd_ok, open_ev, nodata_ev;
  logic take_ev, burst_start_ev, consume_ev, last_word_ev, done_ev;

  assign accept_ev      = (state_q == S_IDLE) && cmd_valid &&
                          (cmd_code == OP_PACKET) && !dma_sel;
  assign cdb_wr_ev      = (state_q == S_PKT_RX) && !cdb_full && wr_valid;
  assign decode_ev      = (state_q == S_PKT_RX) && cdb_full;
  assign rd_ok          = (cdb_op == OP_READ10) && (cdb_blocks != 16'd0);
  assign open_ev        = decode_ev && rd_ok;
  assign nodata_ev      = decode_ev && !rd_ok;
  assign take_ev        = (state_q == S_FILL) && src_valid;
  assign burst_start_ev = take_ev && need_burst_q;
  assign consume_ev     = (state_q == S_XFER) && rd_valid;
  assign last_word_ev   = consume_ev && last_all;
  assign done_ev        = last_word_ev || nodata_ev;

  atapi_cdb_rx #(.CDB_WORDS(CDB_WORDS)) cdb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept_ev),
    .wr_en   (cdb_wr_ev),
    .wr_data (wr_data),
    .full    (cdb_full),
    .opcode  (cdb_op),
    .lba     (cdb_lba),
    .blocks  (cdb_blocks)
  );

  atapi_xfer_ctr #(.BLK_BYTES(BLK_BYTES)) ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (open_ev),
    .blocks     (cdb_blocks),
    .lim        (lim_q),
    .start      (burst_start_ev),
    .consume    (consume_ev),
    .last_all   (last_all),
    .last_burst (last_burst),
    .bc         (bc_out)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (accept_ev) state_d = S_PKT_BSY;
      S_PKT_BSY: state_d = S_PKT_RX;
      S_PKT_RX:  if (decode_ev) state_d = rd_ok ? S_FILL : S_IDLE;
      S_FILL:    if (src_valid) state_d = S_XFER;
      S_XFER:    if (rd_valid) state_d = last_all ? S_IDLE : S_FILL;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      lim_q        <= 16'd2;
      hold_q       <= '0;
      need_burst_q <= 1'b0;
      intr_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_ev) lim_q <= even_limit(bcl);
      if (take_ev) hold_q <= src_data;
      if (open_ev || (consume_ev && last_burst)) need_burst_q <= 1'b1;
      else if (burst_start_ev) need_burst_q <= 1'b0;
      if (burst_start_ev || done_ev) intr_q <= 1'b1;
      else if (intr_ack || accept_ev) intr_q <= 1'b0;
    end
  end

  assign bsy        = (state_q == S_PKT_BSY) || (state_q == S_FILL) ||
                      ((state_q == S_PKT_RX) && cdb_full);
  assign drq        = ((state_q == S_PKT_RX) && !cdb_full) || (state_q == S_XFER);
  assign drdy       = 1'b1;
  assign intrq      = intr_q;
  assign rd_data    = hold_q;
  assign src_open   = open_ev;
  assign src_lba    = cdb_lba;
  assign src_blocks = cdb_blocks;
  assign src_ready  = (state_q == S_FILL);

  AST_DRQ_BSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(drq && bsy)); // R3
  AST_BURST_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start_ev |=> intrq && drq && !bsy); // R6
  AST_FINAL_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> intrq && !drq && !bsy && drdy); // R7
  AST_DMA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_IDLE) && cmd_valid && dma_sel) |=> !bsy && !drq); // R2
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(lim_q)); // R11
  AST_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !src_valid) |=> bsy && !drq); // R10
endmodule

// File: tb/atapi_pio_seq_tb.sv
module atapi_pio_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, dma_sel = 0, wr_valid = 0, rd_valid = 0, intr_ack = 0;
  logic [7:0]  cmd_code = 0;
  logic [15:0] bcl = 0, wr_data = 0, rd_data, bc_out, src_data;
  logic        bsy, drdy, drq, intrq, src_open, src_ready, src_valid;
  logic [31:0] src_lba;
  logic [15:0] src_blocks;

  int total = 0, bad = 0;

  atapi_pio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dma_sel(dma_sel), .bcl(bcl), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .intr_ack(intr_ack),
    .bsy(bsy), .drdy(drdy), .drq(drq), .intrq(intrq), .bc_out(bc_out),
    .src_open(src_open), .src_lba(src_lba), .src_blocks(src_blocks),
    .src_ready(src_ready), .src_valid(src_valid), .src_data(src_data)
  );

  // Block source model: word k of a stream from address A is A[15:0] ^ k*0x0101.
  logic [15:0] mw = 0;
  logic [31:0] m_lba = 0;
  logic [15:0] m_blk = 0;
  logic        slow = 0;
  logic [3:0]  cyc = 0;
  int          opens = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (src_open) begin
      m_lba <= src_lba; m_blk <= src_blocks; mw <= 0; opens <= opens + 1;
    end else if (src_ready && src_valid) mw <= mw + 1'b1;
  end
  assign src_valid = !slow || (cyc[1:0] == 2'b11);
  assign src_data  = m_lba[15:0] ^ (mw * 16'h0101);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] code, input logic dsel, input logic [15:0] lim);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; dma_sel = dsel; bcl = lim;
    @(negedge clk);
    cmd_valid = 0; dma_sel = 0;
  endtask

  task automatic send_cdb(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] cnt);
    logic [15:0] w [6];
    w[0] = {8'h00, op};
    w[1] = {lba[23:16], lba[31:24]};
    w[2] = {lba[7:0], lba[15:8]};
    w[3] = {cnt[15:8], 8'h00};
    w[4] = {8'h00, cnt[7:0]};
    w[5] = 16'h0000;
    for (int i = 0; i < 6; i++) begin
      wr_valid = 1; wr_data = w[i];
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic wait_intr(output bit got);
    got = 0;
    for (int i = 0; i < 600 && !got; i++) begin
      if (intrq) got = 1; else @(negedge clk);
    end
  endtask

  task automatic ack();
    intr_ack = 1; @(negedge clk); intr_ack = 0;
  endtask

  task automatic t_reset();
    chk(!bsy && drdy && !drq && !intrq, "R1 reset status", {bsy, drdy, drq, intrq}, 4'b0100);
  endtask

  task automatic t_ignored();
    issue(8'hA0, 1'b1, 16'd512);
    chk(!bsy && !drq && !intrq, "R2 DMA-select packet ignored", {bsy, drq, intrq}, 0);
    @(negedge clk);
    chk(!bsy && !drq, "R2 DMA-select stays idle", {bsy, drq}, 0);
    issue(8'hEC, 1'b0, 16'd512);
    chk(!bsy && !drq && !intrq, "R2 other command ignored", {bsy, drq, intrq}, 0);
  endtask

  task automatic t_read(input logic [31:0] lba, input logic [15:0] cnt,
                        input logic [15:0] lim_raw, input bit slw, input bit chg, input string tag);
    int lim_e, rem, exp_bc, k, bursts, exp_bursts, errs, bcerr, sterr, op0;
    bit got;
    lim_e = int'(lim_raw) - (int'(lim_raw) % 2);
    if (lim_e < 2) lim_e = 2;
    rem = int'(cnt) * 2048;
    exp_bursts = (rem + lim_e - 1) / lim_e;
    k = 0; bursts = 0; errs = 0; bcerr = 0; sterr = 0; op0 = opens;
    slow = slw;
    issue(8'hA0, 1'b0, lim_raw);
    chk(bsy && !drq, {"R3 busy after packet ", tag}, {bsy, drq}, 2'b10);
    @(negedge clk);
    chk(drq && drdy && !bsy, {"R3 command-block request ", tag}, {drq, drdy, bsy}, 3'b110);
    if (chg) bcl = 16'd2;
    send_cdb(8'h28, lba, cnt);
    while (rem > 0) begin
      wait_intr(got);
      if (!got) begin chk(0, {"R6 burst interrupt timeout ", tag}, 0, 1); return; end
      bursts++;
      if (!(drq && drdy && !bsy)) sterr++;
      exp_bc = (rem < lim_e) ? rem : lim_e;
      if (int'(bc_out) != exp_bc) begin
        if (bcerr == 0) chk(0, {"R5 burst size ", tag}, int'(bc_out), exp_bc);
        bcerr++;
      end
      ack();
      if (intrq) sterr++;
      for (int b = 0; b < exp_bc; b += 2) begin
        for (int t = 0; t < 50 && !drq; t++) begin
          if (!(bsy && !drq)) sterr++;
          @(negedge clk);
        end
        if (rd_data != (lba[15:0] ^ (16'(k) * 16'h0101))) begin
          if (errs == 0) chk(0, {"R9 data word ", tag}, int'(rd_data),
                             int'(lba[15:0] ^ (16'(k) * 16'h0101)));
          errs++;
        end
        rd_valid = 1; @(negedge clk); rd_valid = 0;
        k++; rem -= 2;
      end
    end
    wait_intr(got);
    chk(got && !drq && drdy && !bsy, {"R7 final interrupt ", tag}, {got, drq, drdy, bsy}, 4'b1010);
    ack();
    chk(errs == 0, {"R9 data order ", tag}, errs, 0);
    chk(k == int'(cnt) * 1024 && int'(mw) == k, {"R9 word count ", tag}, int'(mw), k);
    chk(bcerr == 0, {"R5 burst sizes ", tag}, bcerr, 0);
    chk(bursts == exp_bursts, {"R6 burst interrupts ", tag}, bursts, exp_bursts);
    chk(sterr == 0, {"R10 status during bursts ", tag}, sterr, 0);
    chk(m_lba == lba && m_blk == cnt && opens == op0 + 1, {"R4 source address ", tag},
        int'(m_lba), int'(lba));
    if (chg) chk(bcerr == 0, "R11 limit held from issue", bcerr, 0);
    slow = 0;
  endtask

  task automatic t_nodata(input logic [7:0] op, input logic [15:0] cnt, input string tag);
    int op0;
    bit got;
    op0 = opens;
    issue(8'hA0, 1'b0, 16'd4096);
    @(negedge clk);
    send_cdb(op, 32'h0000_1234, cnt);
    wait_intr(got);
    chk(got && !drq && !bsy && drdy, {"R8 immediate completion ", tag}, {got, drq, bsy}, 3'b100);
    ack();
    repeat (3) @(negedge clk);
    chk(opens == op0 && !drq && !bsy && !intrq, {"R8 no source and no data ", tag}, opens - op0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ignored();
    t_read(32'h0001_0203, 16'd1, 16'd5120, 1'b0, 1'b0, "single burst");
    t_read(32'h00A0_0010, 16'd3, 16'd5120, 1'b0, 1'b0, "three blocks");
    t_read(32'h1234_5678, 16'd1, 16'd1001, 1'b1, 1'b0, "odd limit slow source");
    t_read(32'h0000_0007, 16'd1, 16'd1, 1'b0, 1'b0, "limit one");
    t_read(32'h0000_0300, 16'd2, 16'd1536, 1'b0, 1'b1, "limit change");
    t_nodata(8'h28, 16'd0, "zero count");
    t_nodata(8'h12, 16'd4, "other opcode");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule